// File: doc/BRIEF.md
# Sleep-State Wake Event Qualifier

This block gathers every wake source of a platform that is asleep and decides, source by source, whether that source may end the current sleep state. It takes sixteen general-purpose inputs, a storage-controller wake request, the active-low PCIe wake pin, received PME messages and the active-low power button. It also takes a 3-bit sleep-state code from the power sequencer. It raises one wake pulse that the sequencer acts on.

Sources that report an event keep a sticky status bit, and software clears that bit by writing 1 to it. Each source except the power button also has an enable bit. A small register port gives access to both. Eligibility depends on the source's power domain and on the depth of sleep. The eight main-domain inputs and the storage request count only in S1. The standby-domain inputs, the wake pin, PME messages and the power button count in any sleep state.

There is one exception for the storage request. Its status bit may already be set when the platform enters a deep state (S3, S4 or S5). If software has not cleared it, the request still wakes the platform from that deep state.

Top module: `wake_qualifier`

## Requirements
- R1: Reset clears every status bit, every enable bit and the wake output.
- R2: A rising edge on general-purpose input n (n = 0..7, main domain) sets bit n of the event status register at address 0. When bit n of the event enable register at address 1 is set, that bit causes a wake only while the sleep code is 1 (S1).
- R3: Bits 8..15 (standby domain) set their status bits the same way. When enabled, they cause a wake while the sleep code is 1, 3, 4 or 5.
- R4: Status bits are sticky. Writing 1 to a bit at address 0 or address 2 clears it, and writing 0 leaves it unchanged. A new event in the same cycle as a clear wins. The enable registers at addresses 1 and 3 read back what was written, and unused bits read 0.
- R5: A rising edge of the storage request sets bit 0 of the misc status register at address 2. With bit 0 of the misc enable register at address 3 set, it wakes only from S1.
- R6: The sleep code may move from a non-deep code to 3, 4 or 5 while misc status bit 0 is set. If that bit stays set, the storage source wakes the platform in that deep state.
- R7: The wake pin is active low. While it is asserted and bit 2 of the misc enable register is set, it wakes from codes 1, 3, 4 and 5. It never sets any bit of the event status register.
- R8: A single-cycle PME message pulse sets bit 1 of the misc status register. With bit 1 of the misc enable register set, it wakes from any sleep code.
- R9: A falling edge of the active-low power button sets bit 2 of the misc status register. That bit wakes from any sleep code with no enable bit involved.
- R10: No wake is issued while the sleep code is 0 (S0) or an unused code (2, 6, 7).
- R11: The wake output is a one-cycle pulse issued when the OR of (status AND enable AND allowed) rises. A condition that stays true does not repeat the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gp_in | input | 16 | General-purpose inputs, asynchronous; bits 0..7 main domain, 8..15 standby domain |
| stor_wake | input | 1 | Storage-controller wake request, asynchronous, active high |
| pcie_wake_n | input | 1 | PCIe wake pin, asynchronous, active low |
| pme_msg | input | 1 | One-cycle pulse per received PME message, synchronous |
| pwr_btn_n | input | 1 | Power button, asynchronous, active low |
| sleep_state | input | 3 | Current sleep code: 0=S0, 1=S1, 3=S3, 4=S4, 5=S5 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 event status, 1 event enable, 2 misc status, 3 misc enable |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| wake | output | 1 | Single-cycle wake pulse |

## Verification
Asynchronous pins cross two synchronizer flops and an edge register. Their status bits therefore appear after the third clock edge following the stimulus, and the wake pulse follows on the fourth. The wake pin has no edge stage, so its pulse comes on the third edge. A PME message sets its status on the first edge and its pulse on the second. A sleep-code change that makes a pending source eligible gives a pulse on the first edge, or on the second when the storage carry flag must first be captured. Each task drives inputs on the falling edge and counts exactly that many rising edges before it samples. It checks that the wake output is low one cycle earlier, high on the due cycle and low again on the next. Where no wake is expected, it watches the output over a window longer than any of these latencies.

// File: rtl/wake_qualifier.sv
module wake_qualifier #(
  parameter int GP_W   = 16,
  parameter int CORE_N = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [GP_W-1:0] gp_in,
  input  logic            stor_wake,
  input  logic            pcie_wake_n,
  input  logic            pme_msg,
  input  logic            pwr_btn_n,
  input  logic [2:0]      sleep_state,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [15:0]     reg_wdata,
  output logic [15:0]     reg_rdata,
  output logic            wake
);
  localparam int ASYNC_W = GP_W + 3;
  localparam logic [1:0] A_GSTS = 2'd0, A_GEN = 2'd1, A_MSTS = 2'd2, A_MEN = 2'd3;

  // synchronizers: {pwr_btn (inverted), wake pin (inverted), storage, gp}
  logic [ASYNC_W-1:0] raw, s1, s2, s3;
  assign raw = {~pwr_btn_n, ~pcie_wake_n, stor_wake, gp_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= raw; s2 <= s1; s3 <= s2;
    end
  end

  logic [ASYNC_W-1:0] rise;
  assign rise = s2 & ~s3;

  logic [GP_W-1:0] gp_rise;
  logic            stor_rise, btn_press, pin_active;
  assign gp_rise    = rise[GP_W-1:0];
  assign stor_rise  = rise[GP_W];
  assign pin_active = s2[GP_W+1];
  assign btn_press  = rise[GP_W+2];

  logic            in_sleep, deep, is_s1, prev_deep, carry;
  assign is_s1    = sleep_state == 3'd1;
  assign deep     = sleep_state >= 3'd3 && sleep_state <= 3'd5;
  assign in_sleep = is_s1 || deep;

  logic [GP_W-1:0] gp_sts, gp_en;
  logic [2:0]      m_sts, m_en;
  logic            wr_gsts, wr_gen, wr_msts, wr_men;
  assign wr_gsts = reg_wr && reg_addr == A_GSTS;
  assign wr_gen  = reg_wr && reg_addr == A_GEN;
  assign wr_msts = reg_wr && reg_addr == A_MSTS;
  assign wr_men  = reg_wr && reg_addr == A_MEN;

  logic [GP_W-1:0] gp_clr;
  logic [2:0]      m_clr, m_set, m_sts_nx;
  assign gp_clr   = wr_gsts ? reg_wdata[GP_W-1:0] : '0;
  assign m_clr    = wr_msts ? reg_wdata[2:0] : 3'b000;
  assign m_set    = {btn_press, pme_msg, stor_rise};
  assign m_sts_nx = (m_sts & ~m_clr) | m_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gp_sts <= '0; gp_en <= '0; m_sts <= '0; m_en <= '0;
    end else begin
      gp_sts <= (gp_sts & ~gp_clr) | gp_rise;
      m_sts  <= m_sts_nx;
      if (wr_gen) gp_en <= reg_wdata[GP_W-1:0];
      if (wr_men) m_en  <= reg_wdata[2:0];
    end
  end

  // storage status carried into a deep state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_deep <= 1'b0; carry <= 1'b0;
    end else begin
      prev_deep <= deep;
      if (!deep)          carry <= 1'b0;
      else if (!prev_deep) carry <= m_sts[0] && m_sts_nx[0];
      else                 carry <= carry && m_sts_nx[0];
    end
  end

  logic [GP_W-1:0] gp_allow;
  genvar i;
  generate
    for (i = 0; i < GP_W; i++) begin : g_allow
      if (i < CORE_N) begin : g_core
        assign gp_allow[i] = is_s1;
      end else begin : g_stby
        assign gp_allow[i] = in_sleep;
      end
    end
  endgenerate

  logic stor_ok, cond, cond_q;
  assign stor_ok = is_s1 || (deep && carry);
  assign cond = |(gp_sts & gp_en & gp_allow)
              || (m_sts[0] && m_en[0] && stor_ok)
              || (m_sts[1] && m_en[1] && in_sleep)
              || (m_sts[2] && in_sleep)
              || (pin_active && m_en[2] && in_sleep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0; wake <= 1'b0;
    end else begin
      cond_q <= cond;
      wake   <= cond && !cond_q;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_GSTS:  reg_rdata[GP_W-1:0] = gp_sts;
      A_GEN:   reg_rdata[GP_W-1:0] = gp_en;
      A_MSTS:  reg_rdata[2:0]      = m_sts;
      default: reg_rdata[2:0]      = m_en;
    endcase
  end

  AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(in_sleep)); // R10
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake); // R11
  AST_GSTS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_gsts |=> ((gp_sts & $past(gp_sts)) == $past(gp_sts))); // R4
  AST_PME_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    pme_msg |=> m_sts[1]); // R8
  AST_BTN_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_sts[2] && in_sleep && !cond_q) |=> wake); // R9
endmodule

// File: tb/wake_qualifier_bench.sv
module wake_qualifier_bench;
  localparam int CLK_P = 10;
  logic clk = 0, rst_n = 0;
  logic [15:0] gp_in = '0;
  logic stor_wake = 0, pcie_wake_n = 1, pme_msg = 0, pwr_btn_n = 1;
  logic [2:0] sleep_state = 3'd0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic wake;
  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  wake_qualifier u_wake_qualifier (.clk(clk), .rst_n(rst_n), .gp_in(gp_in),
    .stor_wake(stor_wake), .pcie_wake_n(pcie_wake_n), .pme_msg(pme_msg),
    .pwr_btn_n(pwr_btn_n), .sleep_state(sleep_state), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake(wake));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  // stimulus was driven at a falling edge; pulse due on rising edge n
  task automatic expect_pulse(string req, int n);
    repeat (n-1) @(posedge clk);
    #1 chk({req, " early"}, {15'b0, wake}, 16'd0);
    @(posedge clk); #1 chk({req, " pulse"}, {15'b0, wake}, 16'd1);
    @(posedge clk); #1 chk({req, " single"}, {15'b0, wake}, 16'd0);
  endtask

  task automatic expect_none(string req);
    int seen = 0;
    for (int k = 0; k < 8; k++) begin @(posedge clk); #1 seen += wake; end
    chk({req, " no wake"}, 16'(seen), 16'd0);
  endtask

  task automatic cleanup();
    @(negedge clk);
    sleep_state = 0; gp_in = '0; stor_wake = 0; pcie_wake_n = 1; pwr_btn_n = 1;
    wr(2'd1, 16'h0); wr(2'd3, 16'h0); wr(2'd0, 16'hFFFF); wr(2'd2, 16'hFFFF);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int a = 0; a < 4; a++) begin rd(2'(a), d); chk("R1 reg", d, 16'h0); end
    chk("R1 wake", {15'b0, wake}, 16'd0);
  endtask

  task automatic t_core_s1();
    logic [15:0] d;
    @(negedge clk); sleep_state = 1; wr(2'd1, 16'h0008);
    @(negedge clk); gp_in[3] = 1; expect_pulse("R2 core S1", 4);
    rd(2'd0, d); chk("R2 status", d, 16'h0008);
    expect_none("R11 hold");
    cleanup();
  endtask

  task automatic t_core_deep();
    logic [15:0] d;
    @(negedge clk); sleep_state = 3; wr(2'd1, 16'h0004);
    @(negedge clk); gp_in[2] = 1; expect_none("R2 core S3");
    rd(2'd0, d); chk("R2 status deep", d, 16'h0004);
    cleanup();
  endtask

  task automatic t_stby();
    @(negedge clk); sleep_state = 4; wr(2'd1, 16'h0200);
    @(negedge clk); gp_in[9] = 1; expect_pulse("R3 stby S4", 4);
    cleanup();
    @(negedge clk); sleep_state = 5; wr(2'd1, 16'h8000);
    @(negedge clk); gp_in[15] = 1; expect_pulse("R3 stby S5", 4);
    cleanup();
  endtask

  task automatic t_w1c();
    logic [15:0] d;
    @(negedge clk); gp_in = 16'h0011; repeat (4) @(negedge clk);
    rd(2'd0, d); chk("R4 set", d, 16'h0011);
    wr(2'd0, 16'h0001); rd(2'd0, d); chk("R4 w1c", d, 16'h0010);
    wr(2'd0, 16'h0000); rd(2'd0, d); chk("R4 w0", d, 16'h0010);
    wr(2'd3, 16'hFFFF); rd(2'd3, d); chk("R4 en rb", d, 16'h0007);
    wr(2'd1, 16'hA5C3); rd(2'd1, d); chk("R4 gen rb", d, 16'hA5C3);
    cleanup();
  endtask

  task automatic t_stor();
    logic [15:0] d;
    @(negedge clk); sleep_state = 1; wr(2'd3, 16'h0001);
    @(negedge clk); stor_wake = 1; expect_pulse("R5 stor S1", 4);
    cleanup();
    @(negedge clk); sleep_state = 3; wr(2'd3, 16'h0001);
    @(negedge clk); stor_wake = 1; expect_none("R5 stor S3");
    rd(2'd2, d); chk("R5 status", d, 16'h0001);
    cleanup();
  endtask

  task automatic t_carry();
    @(negedge clk); wr(2'd3, 16'h0001);
    @(negedge clk); stor_wake = 1; expect_none("R6 in S0");
    @(negedge clk); sleep_state = 3; expect_pulse("R6 carry", 2);
    cleanup();
  endtask

  task automatic t_pin();
    logic [15:0] d;
    @(negedge clk); sleep_state = 5; wr(2'd3, 16'h0004);
    @(negedge clk); pcie_wake_n = 0; expect_pulse("R7 pin S5", 3);
    rd(2'd0, d); chk("R7 no gpe", d, 16'h0);
    cleanup();
    @(negedge clk); sleep_state = 1;
    @(negedge clk); pcie_wake_n = 0; expect_none("R7 disabled");
    cleanup();
  endtask

  task automatic t_pme();
    logic [15:0] d;
    @(negedge clk); sleep_state = 4; wr(2'd3, 16'h0002);
    @(negedge clk); pme_msg = 1; @(negedge clk); pme_msg = 0;
    expect_pulse("R8 pme", 1);
    rd(2'd2, d); chk("R8 status", d, 16'h0002);
    cleanup();
  endtask

  task automatic t_btn();
    @(negedge clk); sleep_state = 3;
    @(negedge clk); pwr_btn_n = 0; expect_pulse("R9 button", 4);
    cleanup();
  endtask

  task automatic t_awake();
    @(negedge clk); wr(2'd1, 16'hFFFF); wr(2'd3, 16'h0007);
    @(negedge clk); gp_in = 16'hFFFF; pwr_btn_n = 0; pcie_wake_n = 0;
    expect_none("R10 S0");
    @(negedge clk); sleep_state = 2; expect_none("R10 code2");
    @(negedge clk); sleep_state = 7; expect_none("R10 code7");
    @(negedge clk); sleep_state = 1; expect_pulse("R10 to S1", 1);
    cleanup();
  endtask

  initial begin
    #(CLK_P*200000) ;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_core_s1(); t_core_deep(); t_stby(); t_w1c(); t_stor();
    t_carry(); t_pin(); t_pme(); t_btn(); t_awake();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule